// File: doc/BRIEF.md
# Compare-With-Carry Flag Execution Unit

This unit carries out one instruction of a small 8-bit processor core: an 8-bit compare that also subtracts the incoming carry. It takes a 16-bit instruction word together with an issue strobe and decodes two 5-bit register indices from it. It reads both operands from its own 32 x 8 register file and combines them with the current carry and zero flags. It forms the difference internally and throws it away. Only the status flags and the program counter are updated. Because the zero flag can be kept or cleared but never newly set, a chain of these compares run from the low byte to the high byte gives a correct multi-byte equality result.

A test-access write port preloads the register file, a second one preloads the status register, and a read port shows any register. An issued word that does not match the compare pattern raises a one-cycle illegal-opcode flag and changes nothing.

Top module: `cpc_exec_unit`

## Requirements
- R1: An issued word is legal exactly when bits 15:10 equal 000001. The destination index is bits 8:4. The source index is bit 9 (high) joined to bits 3:0.
- R2: The internal result is (Rd - Rr - Cin) modulo 256. Status bit 0 (C) becomes 1 exactly when Rd < Rr + Cin, taken as unsigned values.
- R3: Status bit 5 (H) becomes 1 exactly when the low nibble of Rd is less than the low nibble of Rr plus Cin.
- R4: Status bit 2 (N) is bit 7 of the result. Bit 3 (V) is set when the operands' sign bits differ and the result's sign differs from Rd's sign. Bit 4 (S) is N XOR V.
- R5: Status bit 1 (Z) keeps its previous value when the result is zero and is cleared otherwise. It is never set by the instruction.
- R6: Status bits 6 (T) and 7 (I) are unchanged by an executed instruction.
- R7: A legal issued word updates the status register and adds one to the program counter at the same clock edge.
- R8: An illegal issued word drives `illegal_op` high for exactly the following cycle and leaves the status register and program counter unchanged.
- R9: Executing an instruction writes no register-file entry. Entries change only through the test-access write port.
- R10: The destination and source may be the same register, giving Rd - Rd - Cin.
- R11: Synchronous active-high reset clears the status register, the program counter, `illegal_op` and every register entry.
- R12: When an instruction issues in the same cycle as a register write, it uses the register contents from before the write, and the write still lands. When an instruction issues in the same cycle as a status preload, the preload is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Execute `instr` this cycle |
| instr | input | 16 | Instruction word |
| rf_we | input | 1 | Register-file test write enable |
| rf_waddr | input | 5 | Register-file write index |
| rf_wdata | input | 8 | Register-file write data |
| rf_raddr | input | 5 | Register-file observation index |
| rf_rdata | output | 8 | Register-file observation data |
| sreg_we | input | 1 | Status-register preload enable (ignored when `issue` is high) |
| sreg_wdata | input | 8 | Status-register preload value |
| sreg | output | 8 | Status register {I,T,H,S,V,N,Z,C} |
| pc | output | 16 | Program counter in words |
| illegal_op | output | 1 | Pulses after an illegal issued word |

## Verification
Execution can coincide with either of the two test-access writes. The bench issues a compare in the same cycle as a register write to its own destination operand. It then checks that the flags follow the old operand value while a read-back shows the new one. It also issues a compare together with an all-ones status preload and checks that the status register holds the computed flags and not the preloaded value. Both cases are judged against flags computed in the bench from unsigned and nibble arithmetic.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    parameter int unsigned DATA_W  = 8;
    parameter int unsigned REG_CNT = 32;
    localparam int unsigned IDX_W  = $clog2(REG_CNT);
    localparam int unsigned WORD_W = 16;

    // Status register layout, MSB first: I T H S V N Z C
    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_t;

    typedef struct packed {
        logic             legal;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src;
    } dec_t;

    localparam logic [5:0] CPC_MAJOR = 6'b000001;

    function automatic dec_t decode_word(input logic [WORD_W-1:0] w);
        dec_t d;
        d.legal = (w[15:10] == CPC_MAJOR);
        d.dst   = w[8:4];
        d.src   = {w[9], w[3:0]};
        return d;
    endfunction

endpackage

// File: rtl/cpc_regfile.sv
module cpc_regfile #(
    parameter int unsigned WIDTH = cpc_pkg::DATA_W,
    parameter int unsigned DEPTH = cpc_pkg::REG_CNT,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    ra_a,
    output logic [WIDTH-1:0] rd_a,
    input  logic [AW-1:0]    ra_b,
    output logic [WIDTH-1:0] rd_b,
    input  logic [AW-1:0]    ra_obs,
    output logic [WIDTH-1:0] rd_obs
);

    logic [DEPTH-1:0][WIDTH-1:0] mem;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                mem[g] <= wdata;
            end
        end
    end

    assign rd_a   = mem[ra_a];
    assign rd_b   = mem[ra_b];
    assign rd_obs = mem[ra_obs];

    assert_rf_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !we |=> (mem == $past(mem)));

    assert_rf_write_lands_R12: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/cpc_flag_alu.sv
module cpc_flag_alu
    import cpc_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] op_d,
    input  logic [WIDTH-1:0] op_r,
    input  sreg_t            flags_in,
    output sreg_t            flags_out
);

    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] diff;
    logic [WIDTH-1:0] borrow;
    logic [WIDTH-1:0] ovf;

    always_comb begin
        diff   = op_d - op_r - WIDTH'(flags_in.c);
        borrow = (~op_d & op_r) | (op_r & diff) | (diff & ~op_d);
        ovf    = (op_d & ~op_r & ~diff) | (~op_d & op_r & diff);

        flags_out   = flags_in;
        flags_out.c = borrow[MSB];
        flags_out.h = borrow[3];
        flags_out.n = diff[MSB];
        flags_out.v = ovf[MSB];
        flags_out.s = diff[MSB] ^ ovf[MSB];
        flags_out.z = (diff == '0) ? flags_in.z : 1'b0;
    end

    always_comb begin
        assert_z_never_rises_R5: assert (flags_in.z || !flags_out.z);
    end

endmodule

// File: rtl/cpc_exec_unit.sv
module cpc_exec_unit
    import cpc_pkg::*;
#(
    parameter int unsigned PC_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                issue,
    input  logic [WORD_W-1:0]   instr,
    input  logic                rf_we,
    input  logic [IDX_W-1:0]    rf_waddr,
    input  logic [DATA_W-1:0]   rf_wdata,
    input  logic [IDX_W-1:0]    rf_raddr,
    output logic [DATA_W-1:0]   rf_rdata,
    input  logic                sreg_we,
    input  logic [7:0]          sreg_wdata,
    output logic [7:0]          sreg,
    output logic [PC_W-1:0]     pc,
    output logic                illegal_op
);

    dec_t             dec;
    logic             fire;
    logic [DATA_W-1:0] opd;
    logic [DATA_W-1:0] opr;
    sreg_t            sreg_q;
    sreg_t            sreg_nx;
    logic [PC_W-1:0]  pc_q;
    logic             ill_q;

    assign dec  = decode_word(instr);
    assign fire = issue && dec.legal;

    cpc_regfile #(
        .WIDTH (DATA_W),
        .DEPTH (REG_CNT)
    ) u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (rf_wdata),
        .ra_a   (dec.dst),
        .rd_a   (opd),
        .ra_b   (dec.src),
        .rd_b   (opr),
        .ra_obs (rf_raddr),
        .rd_obs (rf_rdata)
    );

    cpc_flag_alu #(
        .WIDTH (DATA_W)
    ) u_alu (
        .op_d      (opd),
        .op_r      (opr),
        .flags_in  (sreg_q),
        .flags_out (sreg_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            pc_q   <= '0;
            ill_q  <= 1'b0;
        end else begin
            ill_q <= issue && !dec.legal;
            if (fire) begin
                sreg_q <= sreg_nx;
                pc_q   <= pc_q + PC_W'(1);
            end else if (sreg_we && !issue) begin
                sreg_q <= sreg_t'(sreg_wdata);
            end
        end
    end

    assign sreg       = sreg_q;
    assign pc         = pc_q;
    assign illegal_op = ill_q;

    assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
        fire |=> (pc_q == $past(pc_q) + PC_W'(1)));

    assert_illegal_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (issue && !dec.legal) |=> ($stable(sreg_q) && $stable(pc_q) && ill_q));

    assert_z_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (fire && !sreg_q.z) |=> !sreg_q.z);

    assert_ti_kept_R6: assert property (@(posedge clk) disable iff (rst)
        fire |=> (sreg_q.t == $past(sreg_q.t) && sreg_q.i == $past(sreg_q.i)));

    assert_pc_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(pc_q));

endmodule

// File: tb/cpc_exec_unit_bench.sv
module cpc_exec_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue;
    logic [15:0] instr;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [7:0]  rf_wdata;
    logic [4:0]  rf_raddr;
    logic [7:0]  rf_rdata;
    logic        sreg_we;
    logic [7:0]  sreg_wdata;
    logic [7:0]  sreg;
    logic [15:0] pc;
    logic        illegal_op;

    int checks = 0;
    int errors = 0;
    logic [15:0] pc_exp = '0;

    always #2.5 clk = ~clk;

    cpc_exec_unit u_cpc_exec_unit (
        .clk, .rst, .issue, .instr, .rf_we, .rf_waddr, .rf_wdata,
        .rf_raddr, .rf_rdata, .sreg_we, .sreg_wdata, .sreg, .pc, .illegal_op
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int d, input int r);
        return 16'h0400 | 16'((d & 31) << 4) | 16'((r & 16) << 5) | 16'(r & 15);
    endfunction

    // Independent flag model: wide unsigned and nibble arithmetic
    function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] pre);
        logic [8:0] full;
        logic [4:0] lo;
        logic [7:0] res;
        logic c, h, n, v, z;
        full = {1'b0, a} - {1'b0, b} - {8'b0, pre[0]};
        lo   = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'b0, pre[0]};
        res  = full[7:0];
        c = full[8];
        h = lo[4];
        n = res[7];
        v = (a[7] != b[7]) && (res[7] != a[7]);
        z = (res == 8'h00) ? pre[1] : 1'b0;
        return {pre[7:6], h, n ^ v, v, n, z, c};
    endfunction

    task automatic wr_reg(input int a, input logic [7:0] v);
        @(negedge clk);
        rf_we = 1'b1; rf_waddr = 5'(a); rf_wdata = v;
        @(negedge clk);
        rf_we = 1'b0;
    endtask

    task automatic wr_sreg(input logic [7:0] v);
        @(negedge clk);
        sreg_we = 1'b1; sreg_wdata = v;
        @(negedge clk);
        sreg_we = 1'b0;
    endtask

    task automatic run(input logic [15:0] w);
        @(negedge clk);
        issue = 1'b1; instr = w;
        @(negedge clk);
        issue = 1'b0;
    endtask

    task automatic peek(input int a, output logic [7:0] v);
        rf_raddr = 5'(a);
        #0.5;
        v = rf_rdata;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] va [8];
        logic [7:0] vb [8];
        logic [7:0] rv;
        logic [7:0] pre;
        logic [7:0] exp_s;
        va = '{8'h00, 8'hff, 8'hff, 8'h00, 8'haa, 8'h55, 8'h01, 8'h00};
        vb = '{8'h00, 8'hff, 8'h00, 8'hff, 8'h55, 8'haa, 8'h00, 8'h01};

        rst = 1'b1; issue = 1'b0; instr = '0; rf_we = 1'b0; rf_waddr = '0;
        rf_wdata = '0; rf_raddr = '0; sreg_we = 1'b0; sreg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        check("R11 sreg", 16'(sreg), 16'h0);
        check("R11 pc", pc, 16'h0);
        check("R11 illegal", 16'(illegal_op), 16'h0);
        peek(17, rv);
        check("R11 reg", 16'(rv), 16'h0);

        // R1..R7, R9: sweep over carry/zero, register choices and value pairs
        for (int cz = 0; cz < 4; cz++) begin
            for (int d = 0; d < 32; d += 8) begin
                for (int r = 1; r < 32; r += 8) begin
                    for (int k = 0; k < 8; k++) begin
                        wr_reg(d, va[k]);
                        wr_reg(r, vb[k]);
                        pre = {2'(k + d), 2'(k), 2'(r), 2'(cz)};
                        pre[1] = cz[1];
                        pre[0] = cz[0];
                        wr_sreg(pre);
                        exp_s = model(va[k], vb[k], pre);
                        run(enc(d, r));
                        pc_exp = pc_exp + 16'd1;
                        check("R2 R3 R4 R5 R6 flags", 16'(sreg), 16'(exp_s));
                        check("R7 pc", pc, pc_exp);
                        peek(d, rv);
                        check("R9 dst kept", 16'(rv), 16'(va[k]));
                        peek(r, rv);
                        check("R9 src kept R1", 16'(rv), 16'(vb[k]));
                    end
                end
            end
        end

        // R10: same register as both operands, with and without carry
        for (int c = 0; c < 2; c++) begin
            wr_reg(3, 8'h42);
            pre = {6'b110000, 1'b1, 1'(c)};
            wr_sreg(pre);
            exp_s = model(8'h42, 8'h42, pre);
            run(enc(3, 3));
            pc_exp = pc_exp + 16'd1;
            check("R10 same reg", 16'(sreg), 16'(exp_s));
        end

        // R1: high source bit decoding (r = 16 vs r = 0)
        wr_reg(0, 8'h80);
        wr_reg(16, 8'h01);
        wr_reg(7, 8'h01);
        wr_sreg(8'h02);
        run(enc(7, 16));
        pc_exp = pc_exp + 16'd1;
        check("R1 src high bit", 16'(sreg), 16'(model(8'h01, 8'h01, 8'h02)));

        // R8: illegal words leave state alone and pulse illegal_op
        wr_sreg(8'h5a);
        for (int j = 0; j < 4; j++) begin
            logic [15:0] bad;
            case (j)
                0: bad = 16'h0000;
                1: bad = 16'h0800;
                2: bad = 16'hffff;
                default: bad = 16'h0c00;
            endcase
            run(bad);
            check("R8 illegal high", 16'(illegal_op), 16'h1);
            check("R8 sreg kept", 16'(sreg), 16'h5a);
            check("R8 pc kept", pc, pc_exp);
            @(negedge clk);
            check("R8 illegal one cycle", 16'(illegal_op), 16'h0);
        end

        // R12: issue together with a register write to its own operand
        wr_reg(5, 8'h10);
        wr_reg(6, 8'h10);
        wr_sreg(8'h02);
        @(negedge clk);
        issue = 1'b1; instr = enc(5, 6);
        rf_we = 1'b1; rf_waddr = 5'd5; rf_wdata = 8'h20;
        @(negedge clk);
        issue = 1'b0; rf_we = 1'b0;
        pc_exp = pc_exp + 16'd1;
        check("R12 old operand used", 16'(sreg), 16'(model(8'h10, 8'h10, 8'h02)));
        peek(5, rv);
        check("R12 write landed", 16'(rv), 16'h20);

        // R12: issue together with a status preload drops the preload
        wr_sreg(8'h00);
        @(negedge clk);
        issue = 1'b1; instr = enc(5, 6);
        sreg_we = 1'b1; sreg_wdata = 8'hff;
        @(negedge clk);
        issue = 1'b0; sreg_we = 1'b0;
        pc_exp = pc_exp + 16'd1;
        check("R12 preload dropped", 16'(sreg), 16'(model(8'h20, 8'h10, 8'h00)));
        check("R12 pc", pc, pc_exp);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule